// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor that spends several clock cycles on each instruction while sharing one ALU and one memory. It reads the 6-bit major opcode from the instruction register and steps through a Moore state machine. Every cycle it drives the strobes and selects that the datapath needs: loads for the PC, the instruction register, the branch-target register, the register file and memory, plus the mux selects and a 2-bit ALU operation class. The encoding of R-type function codes is left to a separate ALU-control unit. This block only tells that unit to follow the function field.

Every instruction passes through a shared fetch cycle and a shared decode cycle. It then takes a path of its own. A branch finishes in 3 cycles, an R-type operation, an or-immediate or a store in 4, and a load in 5. All outputs come straight from flops and depend only on the current state. As a result, each memory or register-file write enable rises one cycle after the address selects have settled, and it never glitches while the opcode changes.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: `rst_n` is active low and asynchronous. Its release passes through a two-stage synchronizer. While reset is held, and on the first two rising edges after release, the outputs show the fetch state. The first change of state happens on the third rising edge after release.
- R2: The fetch state drives `pc_load`=1, `ir_load`=1, `alu_a_sel`=0 (PC), `alu_b_sel`=00 (constant 4) and `alu_cls`=00 (add). All other strobes are 0. Fetch lasts one cycle and is always followed by decode.
- R3: The decode state drives `tgt_load`=1, `imm_sign`=1, `alu_a_sel`=0, `alu_b_sel`=10 (shifted immediate) and `alu_cls`=00. The next state depends on the opcode: 000100 goes to branch completion, 000000 to R-type execute, 001101 to or-immediate execute, and 100011 or 101011 to address calculation.
- R4: Branch completion drives `pc_load_if_eq`=1, `pc_next_sel`=1, `alu_a_sel`=1 (register), `alu_b_sel`=01 (register) and `alu_cls`=01 (subtract), then returns to fetch. A branch takes 3 cycles.
- R5: R-type execute drives `alu_a_sel`=1, `alu_b_sel`=01, `alu_cls`=11 (follow function field) and `rf_dst_sel`=1. The R-type finish state keeps these values, adds `rf_store`=1 with `rf_src_sel`=0, then returns to fetch. An R-type instruction takes 4 cycles.
- R6: Or-immediate execute drives `alu_a_sel`=1, `alu_b_sel`=11 (immediate), `alu_cls`=10 (or) and `imm_sign`=0. The finish state keeps these values, adds `rf_store`=1 with `rf_dst_sel`=0 and `rf_src_sel`=0, then returns to fetch. This takes 4 cycles.
- R7: Address calculation drives `alu_a_sel`=1, `alu_b_sel`=11, `imm_sign`=1 and `alu_cls`=00. On opcode 101011 it moves to the store state. The store state keeps those selects, adds `mem_store`=1, then returns to fetch. A store takes 4 cycles.
- R8: On opcode 100011, address calculation moves to the load read state. That state keeps the same selects and adds `mem_addr_sel`=1. Next comes the load write-back state, which drives `rf_store`=1, `rf_src_sel`=1 and `rf_dst_sel`=0 with the same ALU selects, then returns to fetch. A load takes 5 cycles.
- R9: Any other opcode in decode returns the sequencer to fetch on the next edge, and no PC, register-file or memory strobe is raised.
- R10: The opcode is sampled only in decode and address calculation. Changing it in any other state has no effect on the outputs or on the sequence.
- R11: In every state, each strobe not named for that state is 0. At most one of `mem_store`, `rf_store`, `pc_load_if_eq` and `tgt_load` is high at once. Whenever `mem_store` is high, the address selects (`alu_a_sel`=1, `alu_b_sel`=11, `alu_cls`=00) already held those values in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode | input | 6 | Major opcode field from the instruction register |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_if_eq | output | 1 | PC write when the ALU zero flag is set |
| mem_addr_sel | output | 1 | Memory address from ALU result (1) or PC (0) |
| mem_store | output | 1 | Memory write enable |
| ir_load | output | 1 | Instruction register write |
| tgt_load | output | 1 | Branch-target register write |
| rf_dst_sel | output | 1 | Destination register from rd field (1) or rt field (0) |
| rf_store | output | 1 | Register-file write enable |
| rf_src_sel | output | 1 | Write-back data from memory (1) or ALU (0) |
| imm_sign | output | 1 | Sign-extend (1) or zero-extend (0) the immediate |
| pc_next_sel | output | 1 | PC source: branch target (1) or ALU (0) |
| alu_a_sel | output | 1 | ALU A operand: register (1) or PC (0) |
| alu_b_sel | output | 2 | ALU B operand: 00 four, 01 register, 10 shifted immediate, 11 immediate |
| alu_cls | output | 2 | ALU class: 00 add, 01 subtract, 10 or, 11 function field |

## Verification
The bench goes after the decision points. These are the decode dispatch for all five opcodes plus an unknown one, and the store-or-load split in address calculation. A design that swapped those encodings would run the wrong path. One that ignored the unknown case would hang or strobe a write. The opcode is also changed in the middle of paths where it must be ignored, which exposes a sequencer that decodes the opcode combinationally in every state. A reset is asserted in the middle of a load, and the release is timed against the synchronizer to find an off-by-one in the reset release. Because every output is compared on every cycle, a stray strobe in a state, or a path that is a cycle too long or too short, shows up as a mismatch.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  typedef enum logic [3:0] {
    ST_FETCH    = 4'd0,
    ST_DECODE   = 4'd1,
    ST_BR_DONE  = 4'd2,
    ST_R_EXEC   = 4'd3,
    ST_R_DONE   = 4'd4,
    ST_ORI_EXEC = 4'd5,
    ST_ORI_DONE = 4'd6,
    ST_ADDR     = 4'd7,
    ST_ST_MEM   = 4'd8,
    ST_LD_MEM   = 4'd9,
    ST_LD_WB    = 4'd10
  } state_e;

  localparam int ALU_CLS_W = 2;
  localparam int BSEL_W    = 2;

  localparam logic [ALU_CLS_W-1:0] CLS_ADD  = 2'b00;
  localparam logic [ALU_CLS_W-1:0] CLS_SUB  = 2'b01;
  localparam logic [ALU_CLS_W-1:0] CLS_OR   = 2'b10;
  localparam logic [ALU_CLS_W-1:0] CLS_FUNC = 2'b11;

  localparam logic [BSEL_W-1:0] BSEL_FOUR  = 2'b00;
  localparam logic [BSEL_W-1:0] BSEL_REG   = 2'b01;
  localparam logic [BSEL_W-1:0] BSEL_BROFF = 2'b10;
  localparam logic [BSEL_W-1:0] BSEL_IMM   = 2'b11;

  typedef struct packed {
    logic                 pc_load;
    logic                 pc_load_if_eq;
    logic                 mem_addr_sel;
    logic                 mem_store;
    logic                 ir_load;
    logic                 tgt_load;
    logic                 rf_dst_sel;
    logic                 rf_store;
    logic                 rf_src_sel;
    logic                 imm_sign;
    logic                 pc_next_sel;
    logic                 alu_a_sel;
    logic [BSEL_W-1:0]    alu_b_sel;
    logic [ALU_CLS_W-1:0] alu_cls;
  } ctrl_t;

  // Strobe and select pattern of one state; don't-care fields are held at 0.
  function automatic ctrl_t ctrl_of(state_e st);
    ctrl_t c;
    c = '0;
    unique case (st)
      ST_FETCH: begin
        c.pc_load   = 1'b1;
        c.ir_load   = 1'b1;
        c.alu_b_sel = BSEL_FOUR;
        c.alu_cls   = CLS_ADD;
      end
      ST_DECODE: begin
        c.tgt_load  = 1'b1;
        c.imm_sign  = 1'b1;
        c.alu_b_sel = BSEL_BROFF;
        c.alu_cls   = CLS_ADD;
      end
      ST_BR_DONE: begin
        c.pc_load_if_eq = 1'b1;
        c.pc_next_sel   = 1'b1;
        c.alu_a_sel     = 1'b1;
        c.alu_b_sel     = BSEL_REG;
        c.alu_cls       = CLS_SUB;
      end
      ST_R_EXEC, ST_R_DONE: begin
        c.rf_dst_sel = 1'b1;
        c.alu_a_sel  = 1'b1;
        c.alu_b_sel  = BSEL_REG;
        c.alu_cls    = CLS_FUNC;
        c.rf_store   = (st == ST_R_DONE);
      end
      ST_ORI_EXEC, ST_ORI_DONE: begin
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = BSEL_IMM;
        c.alu_cls   = CLS_OR;
        c.rf_store  = (st == ST_ORI_DONE);
      end
      ST_ADDR, ST_ST_MEM, ST_LD_MEM, ST_LD_WB: begin
        c.imm_sign     = 1'b1;
        c.alu_a_sel    = 1'b1;
        c.alu_b_sel    = BSEL_IMM;
        c.alu_cls      = CLS_ADD;
        c.mem_store    = (st == ST_ST_MEM);
        c.mem_addr_sel = (st == ST_LD_MEM);
        c.rf_store     = (st == ST_LD_WB);
        c.rf_src_sel   = (st == ST_LD_WB);
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mcc_rst_sync.sv
module mcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[N-2:0], 1'b1};
  end

  assign srst_n = sync_q[N-1];
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
#(
  parameter int              OPW      = 6,
  parameter logic [OPW-1:0]  OP_RTYPE = 6'b000000,
  parameter logic [OPW-1:0]  OP_ORI   = 6'b001101,
  parameter logic [OPW-1:0]  OP_LOAD  = 6'b100011,
  parameter logic [OPW-1:0]  OP_STORE = 6'b101011,
  parameter logic [OPW-1:0]  OP_BEQ   = 6'b000100
) (
  input  state_e          cur,
  input  logic [OPW-1:0]  opcode,
  output state_e          nxt
);
  logic is_rtype, is_ori, is_load, is_store, is_beq;

  always_comb begin
    is_rtype = (opcode == OP_RTYPE);
    is_ori   = (opcode == OP_ORI);
    is_load  = (opcode == OP_LOAD);
    is_store = (opcode == OP_STORE);
    is_beq   = (opcode == OP_BEQ);
  end

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:    nxt = ST_DECODE;
      ST_DECODE: begin
        if      (is_beq)              nxt = ST_BR_DONE;
        else if (is_rtype)            nxt = ST_R_EXEC;
        else if (is_ori)              nxt = ST_ORI_EXEC;
        else if (is_load || is_store) nxt = ST_ADDR;
        else                          nxt = ST_FETCH;
      end
      ST_R_EXEC:   nxt = ST_R_DONE;
      ST_ORI_EXEC: nxt = ST_ORI_DONE;
      ST_ADDR: begin
        if      (is_store) nxt = ST_ST_MEM;
        else if (is_load)  nxt = ST_LD_MEM;
        else               nxt = ST_FETCH;
      end
      ST_LD_MEM:   nxt = ST_LD_WB;
      default:     nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
  import mcc_pkg::*;
(
  input  state_e st,
  output ctrl_t  ctl
);
  always_comb ctl = ctrl_of(st);
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int              OPW         = 6,
  parameter int              SYNC_STAGES = 2,
  parameter logic [OPW-1:0]  OP_RTYPE    = 6'b000000,
  parameter logic [OPW-1:0]  OP_ORI      = 6'b001101,
  parameter logic [OPW-1:0]  OP_LOAD     = 6'b100011,
  parameter logic [OPW-1:0]  OP_STORE    = 6'b101011,
  parameter logic [OPW-1:0]  OP_BEQ      = 6'b000100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OPW-1:0]       opcode,
  output logic                 pc_load,
  output logic                 pc_load_if_eq,
  output logic                 mem_addr_sel,
  output logic                 mem_store,
  output logic                 ir_load,
  output logic                 tgt_load,
  output logic                 rf_dst_sel,
  output logic                 rf_store,
  output logic                 rf_src_sel,
  output logic                 imm_sign,
  output logic                 pc_next_sel,
  output logic                 alu_a_sel,
  output logic [BSEL_W-1:0]    alu_b_sel,
  output logic [ALU_CLS_W-1:0] alu_cls
);
  localparam ctrl_t CTL_AT_RESET = ctrl_of(ST_FETCH);

  logic   srst_n;
  logic   step_en;
  state_e state_q, state_d;
  ctrl_t  ctl_d, ctl_q;

  mcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  mcc_next_state #(
    .OPW(OPW), .OP_RTYPE(OP_RTYPE), .OP_ORI(OP_ORI),
    .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ)
  ) u_next (
    .cur    (state_q),
    .opcode (opcode),
    .nxt    (state_d)
  );

  // Outputs are decoded from the next state and registered with it,
  // so every strobe leaves a flop and follows only the state.
  mcc_out_decode u_dec (
    .st  (state_d),
    .ctl (ctl_d)
  );

  assign step_en = 1'b1;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_FETCH;
      ctl_q   <= CTL_AT_RESET;
    end else if (step_en) begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
    end
  end

  always_comb begin
    pc_load       = ctl_q.pc_load;
    pc_load_if_eq = ctl_q.pc_load_if_eq;
    mem_addr_sel  = ctl_q.mem_addr_sel;
    mem_store     = ctl_q.mem_store;
    ir_load       = ctl_q.ir_load;
    tgt_load      = ctl_q.tgt_load;
    rf_dst_sel    = ctl_q.rf_dst_sel;
    rf_store      = ctl_q.rf_store;
    rf_src_sel    = ctl_q.rf_src_sel;
    imm_sign      = ctl_q.imm_sign;
    pc_next_sel   = ctl_q.pc_next_sel;
    alu_a_sel     = ctl_q.alu_a_sel;
    alu_b_sel     = ctl_q.alu_b_sel;
    alu_cls       = ctl_q.alu_cls;
  end
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker (
  input logic       clk,
  input logic       srst_n,
  input logic       pc_load,
  input logic       pc_load_if_eq,
  input logic       mem_addr_sel,
  input logic       mem_store,
  input logic       ir_load,
  input logic       tgt_load,
  input logic       rf_store,
  input logic       rf_src_sel,
  input logic       alu_a_sel,
  input logic [1:0] alu_b_sel,
  input logic [1:0] alu_cls
);
  // R2: fetch is a single cycle and decode always follows it
  assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!srst_n)
    ir_load |=> (!ir_load && tgt_load && !pc_load));

  // R2: the PC and IR are loaded together
  assert_fetch_pair_R2: assert property (@(posedge clk) disable iff (!srst_n)
    pc_load == ir_load);

  // R4: a conditional PC write ends the branch and returns to fetch
  assert_branch_returns_R4: assert property (@(posedge clk) disable iff (!srst_n)
    pc_load_if_eq |=> ir_load);

  // R5, R6: a register-file write is the last cycle of its path
  assert_rf_write_returns_R5: assert property (@(posedge clk) disable iff (!srst_n)
    rf_store |=> ir_load);

  // R7: the store cycle is followed by fetch
  assert_store_returns_R7: assert property (@(posedge clk) disable iff (!srst_n)
    mem_store |=> ir_load);

  // R8: load write-back comes straight after the memory read cycle
  assert_load_wb_after_read_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (rf_store && rf_src_sel) |-> $past(mem_addr_sel));

  // R11: data-side write strobes never overlap
  assert_wr_exclusive_R11: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({mem_store, rf_store, pc_load_if_eq, tgt_load}));

  // R11: address selects were settled one cycle before the memory write
  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!srst_n)
    mem_store |-> ($past(alu_a_sel) && $past(alu_b_sel) == 2'b11 &&
                   $past(alu_cls) == 2'b00 && $stable(alu_b_sel)));
endmodule

bind mc_ctrl_fsm mcc_checker u_chk (
  .clk           (clk),
  .srst_n        (srst_n),
  .pc_load       (pc_load),
  .pc_load_if_eq (pc_load_if_eq),
  .mem_addr_sel  (mem_addr_sel),
  .mem_store     (mem_store),
  .ir_load       (ir_load),
  .tgt_load      (tgt_load),
  .rf_store      (rf_store),
  .rf_src_sel    (rf_src_sel),
  .alu_a_sel     (alu_a_sel),
  .alu_b_sel     (alu_b_sel),
  .alu_cls       (alu_cls)
);

// File: tb/mc_ctrl_fsm_tb.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_tb;
  localparam logic [5:0] OPC_R   = 6'b000000;
  localparam logic [5:0] OPC_ORI = 6'b001101;
  localparam logic [5:0] OPC_LD  = 6'b100011;
  localparam logic [5:0] OPC_ST  = 6'b101011;
  localparam logic [5:0] OPC_BEQ = 6'b000100;
  localparam logic [5:0] OPC_BAD = 6'b111111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = OPC_R;
  logic pc_load, pc_load_if_eq, mem_addr_sel, mem_store, ir_load, tgt_load;
  logic rf_dst_sel, rf_store, rf_src_sel, imm_sign, pc_next_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_cls;

  always #4 clk = ~clk;

  mc_ctrl_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_load(pc_load), .pc_load_if_eq(pc_load_if_eq), .mem_addr_sel(mem_addr_sel),
    .mem_store(mem_store), .ir_load(ir_load), .tgt_load(tgt_load),
    .rf_dst_sel(rf_dst_sel), .rf_store(rf_store), .rf_src_sel(rf_src_sel),
    .imm_sign(imm_sign), .pc_next_sel(pc_next_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_cls(alu_cls)
  );

  int checks = 0;
  int fails  = 0;
  int mstate = 0;
  int rel_cnt = 0;
  string tag_ovr = "";
  bit done = 1'b0;

  // Reference sequencing per the requirements: state numbers
  // 0 fetch,1 decode,2 branch,3/4 R-type,5/6 or-imm,7 addr,8 store,9/10 load
  function automatic int next_of(int s, logic [5:0] op);
    case (s)
      0: return 1;
      1: begin
        if (op == OPC_BEQ) return 2;
        if (op == OPC_R)   return 3;
        if (op == OPC_ORI) return 5;
        if (op == OPC_LD || op == OPC_ST) return 7;
        return 0;
      end
      3: return 4;
      5: return 6;
      7: begin
        if (op == OPC_ST) return 8;
        if (op == OPC_LD) return 9;
        return 0;
      end
      9: return 10;
      default: return 0;
    endcase
  endfunction

  // Order: pcld,pceq,addrsel,mst,irld,tgt,dst,rfst,src,sign,pcsel,asel,bsel[2],cls[2]
  function automatic logic [15:0] expect_of(int s);
    case (s)
      0:  return {1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00};
      1:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b10,2'b00};
      2:  return {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'b01,2'b01};
      3:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,2'b11};
      4:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,2'b01,2'b11};
      5:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b11,2'b10};
      6:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'b11,2'b10};
      7:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,2'b11,2'b00};
      8:  return {1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,2'b11,2'b00};
      9:  return {1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,2'b11,2'b00};
      10: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,2'b11,2'b00};
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2: return "R4";
      3, 4: return "R5"; 5, 6: return "R6";
      7, 8: return "R7"; default: return "R8";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstate  <= 0;
      rel_cnt <= 0;
    end else if (rel_cnt < 2) begin
      rel_cnt <= rel_cnt + 1;
    end else begin
      mstate <= next_of(mstate, opcode);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [15:0] act, exp_v;
      string t;
      act = {pc_load, pc_load_if_eq, mem_addr_sel, mem_store, ir_load, tgt_load,
             rf_dst_sel, rf_store, rf_src_sel, imm_sign, pc_next_sel, alu_a_sel,
             alu_b_sel, alu_cls};
      exp_v = expect_of(mstate);
      if (tag_ovr != "")               t = tag_ovr;
      else if (!rst_n || rel_cnt < 2)  t = "R1";
      else                             t = tag_of(mstate);
      checks++;
      if (act !== exp_v) begin
        fails++;
        $display("FAIL %s: outputs %b expected %b (ref state %0d)", t, act, exp_v, mstate);
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // Run one instruction from fetch to the next fetch; opcode switches to
  // swap_op after swap_at cycles when swap_at > 0.
  task automatic run_instr(input logic [5:0] op, input string tag,
                           input int swap_at, input logic [5:0] swap_op);
    int n;
    tag_ovr = tag;
    opcode = op;
    while (mstate != 0) tick();
    tick();
    n = 1;
    while (mstate != 0) begin
      if (swap_at > 0 && n == swap_at) opcode = swap_op;
      tick();
      n++;
      if (n > 20) break;
    end
    tag_ovr = "";
  endtask

  task automatic expect_len(input logic [5:0] op, input int len, input string tag);
    int n;
    opcode = op;
    tick();
    while (mstate != 0) tick();
    n = 0;
    // count cycles from fetch until fetch reappears, as seen at the ports
    while (1) begin
      tick();
      n++;
      if (ir_load === 1'b1 || n > 20) break;
    end
    checks++;
    if (n != len) begin
      fails++;
      $display("FAIL %s: instruction length %0d expected %0d", tag, n, len);
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;                      // R1: release through synchronizer
    repeat (4) tick();
    run_instr(OPC_BEQ, "", 0, OPC_BEQ);
    run_instr(OPC_R,   "", 0, OPC_R);
    run_instr(OPC_ORI, "", 0, OPC_ORI);
    run_instr(OPC_ST,  "R11", 0, OPC_ST);
    run_instr(OPC_LD,  "", 0, OPC_LD);
    run_instr(OPC_BAD, "R9", 0, OPC_BAD);
    run_instr(6'b000010, "R9", 0, 6'b000010);
    run_instr(OPC_R,   "R10", 2, OPC_LD);   // change during R-type execute
    run_instr(OPC_ORI, "R10", 2, OPC_ST);   // change during or-imm execute
    run_instr(OPC_LD,  "R10", 3, OPC_BEQ);  // change during load read
    run_instr(OPC_ST,  "R7", 0, OPC_ST);
    expect_len(OPC_BEQ, 3, "R4");
    expect_len(OPC_R,   4, "R5");
    expect_len(OPC_ORI, 4, "R6");
    expect_len(OPC_ST,  4, "R7");
    expect_len(OPC_LD,  5, "R8");
    // R1: reset asserted in the middle of a load
    opcode = OPC_LD;
    while (mstate != 0) tick();
    repeat (3) tick();
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (6) tick();
    run_instr(OPC_R, "", 0, OPC_R);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule